// File: doc/BRIEF.md
# Pointer-Relative Load/Store Address Generator

This block turns one pointer-relative load or store instruction into a series of word requests on a memory port. The instruction word names the base pointer pair, where the offset comes from, whether the offset is applied before the access, whether the pointer is updated, and which register supplies or receives the data. The offset is a signed 16-bit quantity, taken either from a general register or from the instruction's extension word, and is sign-extended to 32 bits before it is added to the 32-bit base.

The surrounding core presents the instruction together with its extension word and an optional block-size prefix, and pulses `start`. While the block is idle it reads the offset register and the base pointer through two combinational read ports. It then issues one word request per acknowledged cycle: consecutive byte addresses two apart, and consecutive register indices wrapping modulo eight. After the last word it pulses `done` and, if the update bit is set, emits a single pointer write-back carrying base plus offset. That gives pre-increment when the offset is applied first and post-increment when it is applied after.

Top module: `ptr_ls_agu`

## Requirements
- R1: An instruction is accepted only when `start` is high, `ready` is high and bits 15..13 equal 011. Any other value of those bits is ignored: `mem_req` stays low and `ready` stays high.
- R2: Every word request carries `mem_we` equal to instruction bit 12 (1 = store) and `mem_reg_is_ptr` equal to bit 11 (1 = pointer register). The first word's `mem_reg_idx` equals bits 10..8.
- R3: With bit 2 = 1 the offset is `ext_word`. With bit 2 = 0 it is the general register named by bits 7..5, read through `gpr_raddr`/`gpr_rdata`. In both cases the offset is sign-extended from 16 to 32 bits.
- R4: Bits 1..0 select the base pointer pair (00 PC, 01 SP, 10 FP, 11 BP). The block reads that pair through `ptr_raddr`/`ptr_rdata`.
- R5: With bit 3 = 1 the first word address is base + offset. With bit 3 = 0 it is the base unchanged.
- R6: With bit 4 = 1, `ptr_wb_en` pulses once, in the `done` cycle. `ptr_wb_idx` then equals bits 1..0 and `ptr_wb_data` equals base + offset, whatever bit 3 is. With bit 4 = 0, `ptr_wb_en` never rises for that instruction.
- R7: With `pfx_en` = 0 one word is transferred. With `pfx_en` = 1, `pfx_sel` values 00, 01, 10 and 11 give 2, 4, 8 and 16 words.
- R8: Each successive word's address is the previous address plus 2, and its `mem_reg_idx` is the previous index plus 1, modulo 8.
- R9: The first request appears in the cycle after acceptance. A request holds its address and index stable until the cycle `mem_ack` is sampled high. The next word appears in the cycle after that acknowledge.
- R10: `done` is high for exactly one cycle, the cycle after the last acknowledge, with `mem_req` low. `ready` returns in the following cycle. A `start` raised while `ready` is low has no effect on the transfer in progress.
- R11: After reset `ready` is high and `mem_req`, `done` and `ptr_wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present |
| instr | input | 16 | Instruction word |
| ext_word | input | 16 | Immediate extension word |
| pfx_en | input | 1 | Block-size prefix active |
| pfx_sel | input | 2 | Block size: 2, 4, 8 or 16 words |
| ready | output | 1 | Idle, can accept an instruction |
| gpr_raddr | output | 3 | Offset register read index |
| gpr_rdata | input | 16 | Offset register read data |
| ptr_raddr | output | 2 | Base pointer pair read index |
| ptr_rdata | input | 32 | Base pointer pair read data |
| mem_req | output | 1 | Word request valid |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | 32 | Byte address of the word |
| mem_reg_is_ptr | output | 1 | Data register is a pointer register |
| mem_reg_idx | output | 3 | Data register index |
| mem_ack | input | 1 | Request accepted this cycle |
| done | output | 1 | Instruction finished |
| ptr_wb_en | output | 1 | Pointer write-back strobe |
| ptr_wb_idx | output | 2 | Pointer pair to update |
| ptr_wb_data | output | 32 | New pointer value |

## Verification
The first request is due one clock after the accepting edge. Each later word is due one clock after the edge that samples its acknowledge. `done` and the write-back are due one clock after the final acknowledge, and `ready` one clock after that. The bench drives every input on the falling edge and samples on the next falling edge, which falls between these registered updates. During wait cycles it also re-samples the held request, to confirm it stays stable until acknowledged. Expected addresses, indices and write-back values come from sign-extension and addition done in the bench over a sweep of all mode bits, pointer pairs, block sizes and acknowledge delays.

// File: rtl/plsa_pkg.sv
package plsa_pkg;

  localparam int INSN_W = 16;

  typedef struct packed {
    logic       is_store;
    logic       data_is_ptr;
    logic [2:0] data_idx;
    logic [2:0] off_gpr;
    logic       upd;
    logic       pre;
    logic       use_imm;
    logic [1:0] pair;
  } ls_fields_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_FIN  = 2'd2
  } seq_state_t;

  function automatic logic in_group(input logic [INSN_W-1:0] w);
    return w[15:13] == 3'b011;
  endfunction

  function automatic ls_fields_t split_fields(input logic [INSN_W-1:0] w);
    ls_fields_t f;
    f.is_store    = w[12];
    f.data_is_ptr = w[11];
    f.data_idx    = w[10:8];
    f.off_gpr     = w[7:5];
    f.upd         = w[4];
    f.pre         = w[3];
    f.use_imm     = w[2];
    f.pair        = w[1:0];
    return f;
  endfunction

endpackage

// File: rtl/plsa_decode.sv
module plsa_decode
  import plsa_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output ls_fields_t        fields,
  output logic              grp_hit
);

  always_comb begin
    fields  = split_fields(instr);
    grp_hit = in_group(instr);
  end

endmodule

// File: rtl/plsa_addr.sv
module plsa_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  imm_off,
  input  logic [OFF_W-1:0]  gpr_off,
  input  logic              use_imm,
  input  logic              pre,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] wb_value
);

  function automatic logic [ADDR_W-1:0] widen(input logic [OFF_W-1:0] v);
    return {{(ADDR_W-OFF_W){v[OFF_W-1]}}, v};
  endfunction

  function automatic logic [ADDR_W-1:0] offset_sum(input logic [ADDR_W-1:0] b,
                                                   input logic [OFF_W-1:0]  o);
    return b + widen(o);
  endfunction

  logic [OFF_W-1:0]  off_sel;
  logic [ADDR_W-1:0] moved;

  always_comb begin
    off_sel    = use_imm ? imm_off : gpr_off;
    moved      = offset_sum(base, off_sel);
    first_addr = pre ? moved : base;
    wb_value   = moved;
  end

endmodule

// File: rtl/plsa_seq.sv
module plsa_seq
  import plsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int PAIR_W = 2,
  parameter int CNT_W  = 5,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] wb_value,
  input  logic              is_store,
  input  logic              data_is_ptr,
  input  logic [IDX_W-1:0]  data_idx,
  input  logic              upd,
  input  logic [PAIR_W-1:0] pair,
  input  logic [CNT_W-1:0]  nwords,
  input  logic              mem_ack,
  output logic              ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_reg_is_ptr,
  output logic [IDX_W-1:0]  mem_reg_idx,
  output logic              done,
  output logic              ptr_wb_en,
  output logic [PAIR_W-1:0] ptr_wb_idx,
  output logic [ADDR_W-1:0] ptr_wb_data,
  output logic              last_word
);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STEP);
  endfunction

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
    return i + IDX_W'(1);
  endfunction

  seq_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] wbv_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  n_q;
  logic              store_q;
  logic              ptr_q;
  logic              upd_q;
  logic [PAIR_W-1:0] pair_q;

  assign last_word = (cnt_q == n_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wbv_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      n_q     <= '0;
      store_q <= 1'b0;
      ptr_q   <= 1'b0;
      upd_q   <= 1'b0;
      pair_q  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (accept) begin
            st      <= S_XFER;
            addr_q  <= first_addr;
            wbv_q   <= wb_value;
            idx_q   <= data_idx;
            cnt_q   <= '0;
            n_q     <= nwords;
            store_q <= is_store;
            ptr_q   <= data_is_ptr;
            upd_q   <= upd;
            pair_q  <= pair;
          end
        end
        S_XFER: begin
          if (mem_ack) begin
            if (last_word) begin
              st <= S_FIN;
            end else begin
              cnt_q  <= cnt_q + CNT_W'(1);
              addr_q <= step_addr(addr_q);
              idx_q  <= step_idx(idx_q);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ready          = (st == S_IDLE);
    mem_req        = (st == S_XFER);
    mem_we         = store_q;
    mem_addr       = addr_q;
    mem_reg_is_ptr = ptr_q;
    mem_reg_idx    = idx_q;
    done           = (st == S_FIN);
    ptr_wb_en      = (st == S_FIN) && upd_q;
    ptr_wb_idx     = pair_q;
    ptr_wb_data    = wbv_q;
  end

endmodule

// File: rtl/ptr_ls_agu.sv
module ptr_ls_agu
  import plsa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int IDX_W     = 3,
  parameter int PAIR_W    = 2,
  parameter int MAX_WORDS = 16,
  parameter int STEP      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INSN_W-1:0] instr,
  input  logic [OFF_W-1:0]  ext_word,
  input  logic              pfx_en,
  input  logic [1:0]        pfx_sel,
  output logic              ready,
  output logic [IDX_W-1:0]  gpr_raddr,
  input  logic [OFF_W-1:0]  gpr_rdata,
  output logic [PAIR_W-1:0] ptr_raddr,
  input  logic [ADDR_W-1:0] ptr_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_reg_is_ptr,
  output logic [IDX_W-1:0]  mem_reg_idx,
  input  logic              mem_ack,
  output logic              done,
  output logic              ptr_wb_en,
  output logic [PAIR_W-1:0] ptr_wb_idx,
  output logic [ADDR_W-1:0] ptr_wb_data
);

  localparam int CNT_W = $clog2(MAX_WORDS + 1);

  function automatic logic [CNT_W-1:0] block_len(input logic en, input logic [1:0] sel);
    return en ? (CNT_W'(2) << sel) : CNT_W'(1);
  endfunction

  ls_fields_t        fields;
  logic              grp_hit;
  logic              accept;
  logic              last_word;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] wb_value;
  logic [CNT_W-1:0]  nwords;

  plsa_decode u_dec (
    .instr   (instr),
    .fields  (fields),
    .grp_hit (grp_hit)
  );

  assign gpr_raddr = fields.off_gpr;
  assign ptr_raddr = fields.pair;
  assign nwords    = block_len(pfx_en, pfx_sel);
  assign accept    = start && ready && grp_hit;

  plsa_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base       (ptr_rdata),
    .imm_off    (ext_word),
    .gpr_off    (gpr_rdata),
    .use_imm    (fields.use_imm),
    .pre        (fields.pre),
    .first_addr (first_addr),
    .wb_value   (wb_value)
  );

  plsa_seq #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .PAIR_W (PAIR_W),
    .CNT_W  (CNT_W),
    .STEP   (STEP)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .accept         (accept),
    .first_addr     (first_addr),
    .wb_value       (wb_value),
    .is_store       (fields.is_store),
    .data_is_ptr    (fields.data_is_ptr),
    .data_idx       (fields.data_idx),
    .upd            (fields.upd),
    .pair           (fields.pair),
    .nwords         (nwords),
    .mem_ack        (mem_ack),
    .ready          (ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_reg_is_ptr (mem_reg_is_ptr),
    .mem_reg_idx    (mem_reg_idx),
    .done           (done),
    .ptr_wb_en      (ptr_wb_en),
    .ptr_wb_idx     (ptr_wb_idx),
    .ptr_wb_data    (ptr_wb_data),
    .last_word      (last_word)
  );

endmodule

// File: rtl/ptr_ls_agu_chk.sv
module ptr_ls_agu_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3,
  parameter int STEP   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              grp_hit,
  input logic              ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [IDX_W-1:0]  mem_reg_idx,
  input logic              done,
  input logic              ptr_wb_en,
  input logic              last_word
);

  p_start_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && ready && grp_hit |=> mem_req);

  p_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !(start && grp_hit) |=> ready && !mem_req);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_reg_idx));

  p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !last_word |=>
      mem_req && mem_addr == $past(mem_addr) + ADDR_W'(STEP)
      && mem_reg_idx == $past(mem_reg_idx) + IDX_W'(1));

  p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && last_word |=> done && !mem_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && ready);

  p_wb_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wb_en |-> done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req && !done);

endmodule

bind ptr_ls_agu ptr_ls_agu_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STEP(STEP)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .grp_hit     (grp_hit),
  .ready       (ready),
  .mem_req     (mem_req),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .mem_reg_idx (mem_reg_idx),
  .done        (done),
  .ptr_wb_en   (ptr_wb_en),
  .last_word   (last_word)
);

// File: tb/ptr_ls_agu_test.sv
`timescale 1ns/1ps
module ptr_ls_agu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] ext_word = '0;
  logic        pfx_en = 1'b0;
  logic [1:0]  pfx_sel = '0;
  logic        ready;
  logic [2:0]  gpr_raddr;
  logic [15:0] gpr_rdata;
  logic [1:0]  ptr_raddr;
  logic [31:0] ptr_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic        mem_reg_is_ptr;
  logic [2:0]  mem_reg_idx;
  logic        mem_ack = 1'b0;
  logic        done;
  logic        ptr_wb_en;
  logic [1:0]  ptr_wb_idx;
  logic [31:0] ptr_wb_data;

  logic [15:0] gpr_m [8];
  logic [31:0] ptr_m [4];
  logic [15:0] ext_tab [4];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign gpr_rdata = gpr_m[gpr_raddr];
  assign ptr_rdata = ptr_m[ptr_raddr];

  ptr_ls_agu uut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .ext_word(ext_word),
    .pfx_en(pfx_en), .pfx_sel(pfx_sel), .ready(ready),
    .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
    .ptr_raddr(ptr_raddr), .ptr_rdata(ptr_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_reg_is_ptr(mem_reg_is_ptr), .mem_reg_idx(mem_reg_idx), .mem_ack(mem_ack),
    .done(done), .ptr_wb_en(ptr_wb_en), .ptr_wb_idx(ptr_wb_idx), .ptr_wb_data(ptr_wb_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_instr(input logic [15:0] w, input logic [15:0] ext,
                           input logic pen, input logic [1:0] psel,
                           input int wait_cyc, input bit poke);
    logic [31:0] off32, base, acc0, exp_wb;
    int nw;
    off32  = w[2] ? {{16{ext[15]}}, ext} : {{16{gpr_m[w[7:5]][15]}}, gpr_m[w[7:5]]};
    base   = ptr_m[w[1:0]];
    exp_wb = base + off32;
    acc0   = w[3] ? exp_wb : base;
    nw     = pen ? (2 << psel) : 1;
    start = 1'b1; instr = w; ext_word = ext; pfx_en = pen; pfx_sel = psel;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after accept", {31'd0, ready}, 32'd0);
    for (int k = 0; k < nw; k++) begin
      for (int d = 0; d < wait_cyc; d++) begin
        mem_ack = 1'b0;
        if (poke && k == 0 && d == 0) begin
          start = 1'b1; instr = w ^ 16'h00F7; ext_word = ~ext;
        end
        chk("R9 req held", {31'd0, mem_req}, 32'd1);
        chk("R9 addr held", mem_addr, acc0 + 32'(2 * k));
        @(negedge clk);
        start = 1'b0;
      end
      mem_ack = 1'b1;
      chk("R9 req", {31'd0, mem_req}, 32'd1);
      if (k == 0) chk("R5 R3 R4 first addr", mem_addr, acc0);
      else        chk("R8 addr step", mem_addr, acc0 + 32'(2 * k));
      chk("R8 R2 reg idx", {29'd0, mem_reg_idx}, {29'd0, 3'(w[10:8] + 3'(k))});
      chk("R2 we", {31'd0, mem_we}, {31'd0, w[12]});
      chk("R2 is_ptr", {31'd0, mem_reg_is_ptr}, {31'd0, w[11]});
      chk("R10 no done mid", {31'd0, done}, 32'd0);
      @(negedge clk);
    end
    mem_ack = 1'b0;
    chk("R7 R10 done after count", {31'd0, done}, 32'd1);
    chk("R10 req low at done", {31'd0, mem_req}, 32'd0);
    chk("R6 wb_en", {31'd0, ptr_wb_en}, {31'd0, w[4]});
    if (w[4]) begin
      chk("R6 wb idx", {30'd0, ptr_wb_idx}, {30'd0, w[1:0]});
      chk("R6 wb data", ptr_wb_data, exp_wb);
    end
    @(negedge clk);
    chk("R10 done pulse", {31'd0, done}, 32'd0);
    chk("R10 ready back", {31'd0, ready}, 32'd1);
    chk("R6 wb once", {31'd0, ptr_wb_en}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    gpr_m[0] = 16'h0000; gpr_m[1] = 16'h0004; gpr_m[2] = 16'hFFFE; gpr_m[3] = 16'h7FFF;
    gpr_m[4] = 16'h8000; gpr_m[5] = 16'h0100; gpr_m[6] = 16'hFFF0; gpr_m[7] = 16'h0033;
    ptr_m[0] = 32'h0000_1000; ptr_m[1] = 32'h0001_FFFE;
    ptr_m[2] = 32'hFFFF_FFF0; ptr_m[3] = 32'h8000_0000;
    ext_tab[0] = 16'h0010; ext_tab[1] = 16'h8000; ext_tab[2] = 16'hFFFF; ext_tab[3] = 16'h7FFF;

    repeat (3) @(negedge clk);
    chk("R11 ready", {31'd0, ready}, 32'd1);
    chk("R11 req", {31'd0, mem_req}, 32'd0);
    chk("R11 done", {31'd0, done}, 32'd0);
    chk("R11 wb", {31'd0, ptr_wb_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int g = 0; g < 8; g++) begin
      if (g != 3) begin
        start = 1'b1; instr = {3'(g), 13'h1F1D};
        @(negedge clk);
        start = 1'b0;
        chk("R1 other group no req", {31'd0, mem_req}, 32'd0);
        chk("R1 other group ready", {31'd0, ready}, 32'd1);
      end
    end

    for (int mode = 0; mode < 8; mode++) begin
      for (int pair = 0; pair < 4; pair++) begin
        for (int pf = 0; pf < 5; pf++) begin
          logic [15:0] w;
          w = {3'b011, 1'((pair + mode) & 1), 1'(pf & 1), 3'((mode + pair + pf) & 7),
               3'((mode * 3 + pair) & 7), 3'(mode), 2'(pair)};
          run_instr(w, ext_tab[(pair + pf) & 3], pf != 0, 2'((pf + 3) & 3),
                    (mode + pf) % 3, (mode == 5 && pf == 2));
        end
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule